// File: doc/BRIEF.md
# Predicate Reverse and Unpack Unit

This unit rearranges a single predicate word in one of two ways. It takes a source predicate, an active length in bytes, and a few control fields, and returns a registered destination predicate one cycle after a valid strobe.

In **reverse** mode the unit reverses the order of the element units in the active part of the word. An element unit is 1, 2, 4 or 8 bits wide, chosen by a 2-bit size code. In **unpack** mode it takes either the lower or the upper half of the active bits. Each bit of that half becomes a 2-bit unit whose upper bit is zero, so the result fills the whole active length.

In both modes, destination bits at or beyond the active length are zero. The length can be any value from 1 to the word size in bytes, including values that are not a power of two. A surrounding pipeline presents an operation together with `in_valid` and picks up the result when `done` is high.

Top module: `pred_revunpk`

## Requirements
- R1: After reset, `done` is 0 and `dst` is all zeros.
- R2: `done` is high in exactly the cycle after a cycle in which `in_valid` was high, and `dst` carries that operation's result in the same cycle.
- R3: While `in_valid` is low, `dst` keeps its previous value.
- R4: With `op`=0 (reverse), the active bits (8 × `act_len`) are treated as units of 2^`esz` bits. The size codes are 0 = 1 bit, 1 = 2 bits, 2 = 4 bits and 3 = 8 bits. Unit k of the source lands at unit position (count − 1 − k) of the destination, and the bit order inside each unit is kept.
- R5: Running reverse on the result of a reverse with the same size and length gives back the source bits below 8 × `act_len`.
- R6: With `op`=1 (unpack) and `hi_sel`=0, source bit i (for i < 4 × `act_len`) appears at destination bit 2i, and every odd destination bit is zero.
- R7: With `op`=1 and `hi_sel`=1, source bit 4 × `act_len` + i appears at destination bit 2i, for i < 4 × `act_len`.
- R8: In unpack mode, `esz` has no effect on the result.
- R9: Destination bits at or above 8 × `act_len` are zero. Source bits at or above that boundary do not affect the result, and `act_len`=0 gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Starts an operation this cycle |
| op | input | 1 | 0 = reverse, 1 = unpack |
| esz | input | 2 | Element size code for reverse: unit is 2^esz bits |
| hi_sel | input | 1 | Unpack half select: 0 = lower, 1 = upper |
| act_len | input | $clog2(PRED_BYTES+1) | Active length in bytes |
| src | input | 8×PRED_BYTES | Source predicate |
| done | output | 1 | Result valid this cycle |
| dst | output | 8×PRED_BYTES | Registered destination predicate |

## Verification
Every result is due exactly one clock edge after its strobe. The bench drives `in_valid` and the operands on a falling edge, drops `in_valid` on the next falling edge, and samples `done` and `dst` there, after the single register has loaded. Holding is checked by letting idle cycles pass and sampling `dst` again on a later falling edge. The double-reverse test feeds the sampled output back as the next source, so each of its checks takes two strobes.

// File: rtl/pred_perm_pkg.sv
package pred_perm_pkg;
   typedef enum logic {
      PERM_REVERSE = 1'b0,
      PERM_UNPACK  = 1'b1
   } perm_op_e;
endpackage

// File: rtl/pred_unit_rev.sv
// Reverses units of 2^esz bits across the full word (byte swap + sub-byte swap stages).
module pred_unit_rev #(
   parameter int W = 64
) (
   input  logic [W-1:0] din,
   input  logic [1:0]   esz,
   output logic [W-1:0] dout
);
   localparam int NBYTES = W / 8;

   if (W % 8 != 0) begin : g_bad_w
      $error("pred_unit_rev: W must be a multiple of 8");
   end

   // mask selecting the lower half of every 2*2^s-bit group
   function automatic logic [W-1:0] low_mask(input int s);
      logic [W-1:0] m;
      for (int b = 0; b < W; b++) m[b] = ((b >> s) & 1) == 0;
      return m;
   endfunction

   logic [W-1:0] stg [0:3];

   for (genvar b = 0; b < NBYTES; b++) begin : g_bswap
      assign stg[3][8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
   end

   for (genvar s = 2; s >= 0; s--) begin : g_stage
      localparam int SH = 1 << s;
      localparam logic [W-1:0] M = low_mask(s);
      logic [W-1:0] swapped;
      assign swapped = ((stg[s+1] & M) << SH) | ((stg[s+1] >> SH) & M);
      assign stg[s]  = (int'(esz) <= s) ? swapped : stg[s+1];
   end

   assign dout = stg[0];
endmodule

// File: rtl/pred_bit_spread.sv
// Spreads each input bit into a 2-bit unit with a zero upper bit.
module pred_bit_spread #(
   parameter int HW = 32
) (
   input  logic [HW-1:0]   din,
   output logic [2*HW-1:0] dout
);
   if (HW < 1) begin : g_bad_hw
      $error("pred_bit_spread: HW must be positive");
   end

   for (genvar i = 0; i < HW; i++) begin : g_sp
      assign dout[2*i]   = din[i];
      assign dout[2*i+1] = 1'b0;
   end
endmodule

// File: rtl/pred_revunpk.sv
module pred_revunpk
   import pred_perm_pkg::*;
#(
   parameter int PRED_BYTES = 8,
   localparam int W     = 8 * PRED_BYTES,
   localparam int HALF  = W / 2,
   localparam int LEN_W = $clog2(PRED_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             op,
   input  logic [1:0]       esz,
   input  logic             hi_sel,
   input  logic [LEN_W-1:0] act_len,
   input  logic [W-1:0]     src,
   output logic             done,
   output logic [W-1:0]     dst
);
   if (PRED_BYTES < 1) begin : g_bad_bytes
      $error("pred_revunpk: PRED_BYTES must be at least 1");
   end

   function automatic logic [W-1:0] len_mask(input int nb);
      logic [W-1:0] m;
      for (int b = 0; b < W; b++) m[b] = (b < nb);
      return m;
   endfunction

   int            nbits;
   int            lshift;
   logic [W-1:0]  keep_mask;
   logic [W-1:0]  aligned;
   logic [W-1:0]  rev_out;
   logic [W-1:0]  half_src;
   logic [HALF-1:0] half_bits;
   logic [W-1:0]  spread_out;
   logic [W-1:0]  result;
   perm_op_e      op_e;

   always_comb begin
      op_e      = perm_op_e'(op);
      nbits     = 8 * int'(act_len);
      lshift    = (nbits >= W) ? 0 : W - nbits;
      keep_mask = len_mask(nbits);
      aligned   = src << lshift;
      half_src  = hi_sel ? (src >> (nbits / 2)) : src;
      half_bits = half_src[HALF-1:0] & keep_mask[HALF-1:0] & len_mask(nbits / 2)[HALF-1:0];
   end

   pred_unit_rev #(.W(W)) u_rev (
      .din  (aligned),
      .esz  (esz),
      .dout (rev_out)
   );

   pred_bit_spread #(.HW(HALF)) u_spread (
      .din  (half_bits),
      .dout (spread_out)
   );

   always_comb begin
      result = ((op_e == PERM_UNPACK) ? spread_out : rev_out) & keep_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         dst  <= '0;
      end else begin
         done <= in_valid;
         if (in_valid) dst <= result;
      end
   end

   localparam logic [W-1:0] ODD_BITS = {HALF{2'b10}};

   // R2
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> done);
   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !done);
   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(dst));
   // R9
   above_len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (dst & ~len_mask(8 * int'($past(act_len)))) == '0);
   // R6
   unpack_odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op) |=> (dst & ODD_BITS) == '0);
   // R4
   rev_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op) |=>
         $countones(dst) == $countones($past(src) & len_mask(8 * int'($past(act_len)))));
endmodule

// File: tb/pred_revunpk_tb.sv
module pred_revunpk_tb;
   localparam int PB = 8;
   localparam int W  = 8 * PB;
   localparam int LW = $clog2(PB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          op = 1'b0;
   logic [1:0]    esz = 2'd0;
   logic          hi_sel = 1'b0;
   logic [LW-1:0] act_len = '0;
   logic [W-1:0]  src = '0;
   logic          done;
   logic [W-1:0]  dst;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   pred_revunpk #(.PRED_BYTES(PB)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esz(esz),
      .hi_sel(hi_sel), .act_len(act_len), .src(src), .done(done), .dst(dst)
   );

   // {op, esz, hi, len, src, expected}
   localparam int VW = 1 + 2 + 1 + 4 + 64 + 64;
   localparam logic [VW-1:0] VEC [10] = '{
      {1'b0, 2'd0, 1'b0, 4'd1, 64'h01,       64'h80},       // R4 bit
      {1'b0, 2'd3, 1'b0, 4'd2, 64'h1234,     64'h3412},     // R4 bytes
      {1'b0, 2'd2, 1'b0, 4'd1, 64'hA5,       64'h5A},       // R4 nibbles
      {1'b0, 2'd1, 1'b0, 4'd1, 64'h1B,       64'hE4},       // R4 pairs
      {1'b1, 2'd0, 1'b0, 4'd2, 64'hFF0F,     64'h0055},     // R6
      {1'b1, 2'd0, 1'b1, 4'd2, 64'hFF0F,     64'h5555},     // R7
      {1'b1, 2'd0, 1'b1, 4'd3, 64'hFFF000,   64'h555555},   // R7 odd length
      {1'b0, 2'd0, 1'b0, 4'd3, 64'h000001,   64'h800000},   // R4 odd length
      {1'b1, 2'd3, 1'b0, 4'd1, 64'h03,       64'h05},       // R8
      {1'b0, 2'd0, 1'b0, 4'd1, 64'hFF01,     64'h80}        // R9
   };

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // drive one operation on a falling edge, sample one cycle later
   task automatic run(input logic o, input logic [1:0] e, input logic h,
                      input int len, input logic [W-1:0] s);
      @(negedge clk);
      in_valid = 1'b1; op = o; esz = e; hi_sel = h; act_len = LW'(len); src = s;
      @(negedge clk);
      in_valid = 1'b0;
      total++;
      if (done !== 1'b1) begin
         bad++;
         $display("FAIL R2 done act=%b exp=1", done);
      end
   endtask

   function automatic logic [W-1:0] ref_rev(input logic [W-1:0] s, input int e, input int len);
      logic [W-1:0] r = '0;
      int ub = 1 << e;
      int nb = 8 * len;
      for (int k = 0; k < nb; k++) begin
         int u = k / ub;
         r[(nb / ub - 1 - u) * ub + (k % ub)] = s[k];
      end
      return r;
   endfunction

   function automatic logic [W-1:0] ref_unp(input logic [W-1:0] s, input logic h, input int len);
      logic [W-1:0] r = '0;
      int base = h ? 4 * len : 0;
      for (int i = 0; i < 4 * len; i++) r[2 * i] = s[base + i];
      return r;
   endfunction

   function automatic logic [W-1:0] lmask(input int len);
      logic [W-1:0] m;
      for (int b = 0; b < W; b++) m[b] = (b < 8 * len);
      return m;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      report();
   end

   initial begin
      logic [W-1:0] first;
      logic [W-1:0] pat;
      logic [W-1:0] held;

      // R1 reset state
      repeat (2) @(negedge clk);
      check("R1 dst", dst, '0);
      check("R1 done", {{(W-1){1'b0}}, done}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      foreach (VEC[i]) begin
         run(VEC[i][135], VEC[i][134:133], VEC[i][132], int'(VEC[i][131:128]), VEC[i][127:64]);
         check("R4/R6/R7/R8/R9 table", dst, VEC[i][63:0]);
      end

      // R3 hold: idle cycles keep the last result
      held = dst;
      src = '1;
      esz = 2'd2;
      repeat (3) @(negedge clk);
      check("R3 hold", dst, held);
      total++;
      if (done !== 1'b0) begin
         bad++;
         $display("FAIL R2 done idle act=%b exp=0", done);
      end

      // R4/R5: reference plus double reverse, every esz and length
      for (int e = 0; e < 4; e++) begin
         for (int len = 1; len <= PB; len++) begin
            pat = 64'hC3A5_0F96_7E21_D84B ^ (64'(e) << 7) ^ 64'(len * 37);
            run(1'b0, 2'(e), 1'b0, len, pat);
            first = dst;
            check("R4 reverse ref", first, ref_rev(pat, e, len));
            run(1'b0, 2'(e), 1'b0, len, first);
            check("R5 double reverse", dst, pat & lmask(len));
         end
      end

      // R6/R7/R8: unpack against bit reference, esz varied
      for (int len = 1; len <= PB; len++) begin
         for (int h = 0; h < 2; h++) begin
            pat = 64'h9B3F_6102_E4D7_58AC + 64'(len * 1031 + h);
            run(1'b1, 2'(len % 4), 1'(h), len, pat);
            check(h ? "R7 unpack hi" : "R6 unpack lo", dst, ref_unp(pat, 1'(h), len));
         end
      end

      // R8: same unpack with each esz yields one answer
      for (int e = 0; e < 4; e++) begin
         run(1'b1, 2'(e), 1'b1, 5, 64'hFFFF_FF5A_C3F0_0F3C);
         check("R8 esz ignored", dst, ref_unp(64'hFFFF_FF5A_C3F0_0F3C, 1'b1, 5));
      end

      // R9: zero length and full-width source
      run(1'b0, 2'd0, 1'b0, 0, '1);
      check("R9 len zero reverse", dst, '0);
      run(1'b1, 2'd0, 1'b1, 0, '1);
      check("R9 len zero unpack", dst, '0);
      run(1'b0, 2'd3, 1'b0, 3, '1);
      check("R9 above length", dst, 64'h0000_0000_00FF_FFFF);

      report();
   end
endmodule